// File: doc/BRIEF.md
# Asynchronous DRAM Access and Refresh Sequencer

This block sits between a simple request port and an asynchronous DRAM. The DRAM has one shared address bus for row and column, two active-low strobes (row and column), an active-low write enable and a bidirectional data bus. A user hands the block a full address, a direction and, for a write, the data. The block splits the address into its row half and its column half and walks the strobes through a complete access. Read data comes back as a one-cycle pulse.

A free-running interval timer keeps the array alive. Each time the interval expires, a refresh is owed. The block services it at the first idle point, ahead of any waiting request. A refresh drops the column strobe first and the row strobe second, so the memory uses its own internal row counter. Every pulse width and gap is a cycle count taken from configuration inputs. The inputs are sampled while the sequencer works, and a zero is read as one.

Top module: `adram_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, both strobes and write enable are high, the data bus is released, `rd_valid` is low, and `req_ready` is high when no refresh is owed.
- R2: For an access, the row part `req_addr[AW-1:COL_W]` is on `dram_addr` when the row strobe falls. The column part `req_addr[COL_W-1:0]` is on `dram_addr` when the column strobe falls. The row strobe falls exactly `cfg_rcd` cycles before the column strobe.
- R3: In an access, the column strobe stays low for exactly `cfg_cas` cycles and the row strobe stays low for `cfg_rcd + cfg_cas` cycles. Both rise on the same edge.
- R4: After any strobe cycle, both strobes stay high for at least `cfg_pre + 1` cycles. When a request is already waiting, this gap is exactly `cfg_pre + 1` cycles.
- R5: For a write, write enable is already low in the cycle before the column strobe falls, stays unchanged while the column strobe is low, and the write data is on the bus at the column strobe fall. Reads and refreshes keep write enable high.
- R6: Read data is sampled from the bus in the last cycle of the column strobe pulse. It is presented on `rd_data` with a single-cycle `rd_valid` in the cycle in which the column strobe is first seen high again.
- R7: A refresh drops the column strobe while the row strobe is high. The row strobe follows `cfg_rcd` cycles later and stays low for `cfg_cas` cycles. The column strobe is low for `cfg_rcd + cfg_cas` cycles.
- R8: With `cfg_ref_period` = P > 0 and no traffic, a refresh starts every P cycles. With P = 0, no refresh is ever started.
- R9: An owed refresh is serviced before any new request and right after the access in flight, so under continuous traffic the gap between refreshes stays within P plus one access length.
- R10: The block drives the data bus only while write enable is low for a write. A read therefore returns the value the memory drives, which is the last value written to that address.
- R11: A zero in `cfg_rcd`, `cfg_cas` or `cfg_pre` behaves as a value of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rcd | input | TW | Row-to-column strobe delay in cycles |
| cfg_cas | input | TW | Column strobe pulse width in cycles |
| cfg_pre | input | TW | Precharge cycles after each strobe cycle |
| cfg_ref_period | input | PW | Refresh interval in cycles, 0 disables |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ROW_W+COL_W | Full word address, row in the upper bits |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request is taken on this edge when valid |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DW | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq | inout | DW | Bidirectional data bus |

## Verification
The hardest situation to reach is a refresh that comes due while an access is in flight. A refresh that starts from idle shows nothing about preemption, and the interval timer is not visible at the ports. The bench handles this with a short refresh interval set against back-to-back write/read traffic, so expiries land at every phase of an access. It then bounds the spacing of refresh starts and confirms that every readback still matches. A sweep over all small strobe timings, including zeros, makes each pulse width, gap and data capture point visible as a cycle count that the bench predicts arithmetically.

// File: rtl/adram_pkg.sv
package adram_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_ROW  = 3'd1,
    SQ_COL  = 3'd2,
    SQ_RCAS = 3'd3,
    SQ_RRAS = 3'd4,
    SQ_PRE  = 3'd5
  } sq_state_e;
endpackage

// File: rtl/adram_refresh_timer.sv
module adram_refresh_timer #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period,
  input  logic          ack,
  output logic          pend
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          run, tick;

  assign run  = (period != '0);
  assign tick = run && (cnt_q >= period - PW'(1));

  always_comb begin
    if (!run) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      cnt_d  = tick ? '0 : cnt_q + PW'(1);
      // a new expiry wins over an acknowledge in the same cycle
      pend_d = tick ? 1'b1 : (ack ? 1'b0 : pend_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/adram_seq.sv
module adram_seq
  import adram_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_rcd,
  input  logic [TW-1:0] cfg_cas,
  input  logic [TW-1:0] cfg_pre,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          ref_pend,
  output logic          req_ready,
  output logic          accept,
  output logic          ref_ack,
  output logic          ld_col,
  output logic          cap,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          dq_oe
);
  sq_state_e     st_q, nxt;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          wr_q, wr_d;
  logic          last;
  logic          ras_d, cas_d, wen_d, oe_d;
  logic          ras_q, cas_q, wen_q, oe_q;

  // load value for a down counter; zero and one both give one cycle
  function automatic logic [TW-1:0] ld_cnt(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - TW'(1);
  endfunction

  assign last      = (cnt_q == '0);
  assign req_ready = (st_q == SQ_IDLE) && !ref_pend;

  always_comb begin
    nxt     = st_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    accept  = 1'b0;
    ref_ack = 1'b0;
    cap     = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        cnt_d = '0;
        if (ref_pend) begin
          nxt     = SQ_RCAS;
          cnt_d   = ld_cnt(cfg_rcd);
          wr_d    = 1'b0;
          ref_ack = 1'b1;
        end else if (req_valid) begin
          nxt    = SQ_ROW;
          cnt_d  = ld_cnt(cfg_rcd);
          wr_d   = req_write;
          accept = 1'b1;
        end
      end
      SQ_ROW: begin
        if (last) begin
          nxt   = SQ_COL;
          cnt_d = ld_cnt(cfg_cas);
        end else begin
          cnt_d = cnt_q - TW'(1);
        end
      end
      SQ_COL: begin
        if (last) begin
          nxt   = SQ_PRE;
          cnt_d = ld_cnt(cfg_pre);
          cap   = !wr_q;
        end else begin
          cnt_d = cnt_q - TW'(1);
        end
      end
      SQ_RCAS: begin
        if (last) begin
          nxt   = SQ_RRAS;
          cnt_d = ld_cnt(cfg_cas);
        end else begin
          cnt_d = cnt_q - TW'(1);
        end
      end
      SQ_RRAS: begin
        if (last) begin
          nxt   = SQ_PRE;
          cnt_d = ld_cnt(cfg_pre);
        end else begin
          cnt_d = cnt_q - TW'(1);
        end
      end
      SQ_PRE: begin
        if (last) begin
          nxt   = SQ_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - TW'(1);
        end
      end
      default: nxt = SQ_IDLE;
    endcase
  end

  // pin levels decoded from the next state, so each pin leaves a flop
  always_comb begin
    ras_d = !((nxt == SQ_ROW) || (nxt == SQ_COL) || (nxt == SQ_RRAS));
    cas_d = !((nxt == SQ_COL) || (nxt == SQ_RCAS) || (nxt == SQ_RRAS));
    wen_d = !(((nxt == SQ_ROW) || (nxt == SQ_COL)) && wr_d);
    oe_d  = ((nxt == SQ_ROW) || (nxt == SQ_COL)) && wr_d;
  end

  assign ld_col = (st_q == SQ_ROW) && (nxt == SQ_COL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      wr_q  <= 1'b0;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      wen_q <= 1'b1;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= nxt;
      cnt_q <= cnt_d;
      wr_q  <= wr_d;
      ras_q <= ras_d;
      cas_q <= cas_d;
      wen_q <= wen_d;
      oe_q  <= oe_d;
    end
  end

  assign ras_n = ras_q;
  assign cas_n = cas_q;
  assign we_n  = wen_q;
  assign dq_oe = oe_q;
endmodule

// File: rtl/adram_datapath.sv
module adram_datapath #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int DW    = 8,
  localparam int AW   = ROW_W + COL_W,
  localparam int MAW  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           ld_col,
  input  logic           cap,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [DW-1:0]  dq_in,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid
);
  logic [MAW-1:0]   addr_q, addr_d;
  logic [COL_W-1:0] col_q;
  logic [DW-1:0]    wd_q, rd_q;
  logic             rv_q;

  always_comb begin
    addr_d = addr_q;
    if (accept)      addr_d = MAW'(req_addr[AW-1:COL_W]);
    else if (ld_col) addr_d = MAW'(col_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      col_q  <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      rv_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      rv_q   <= cap;
      if (accept) begin
        col_q <= req_addr[COL_W-1:0];
        wd_q  <= req_wdata;
      end
      if (cap) rd_q <= dq_in;
    end
  end

  assign mem_addr = addr_q;
  assign wdata    = wd_q;
  assign rd_data  = rd_q;
  assign rd_valid = rv_q;
endmodule

// File: rtl/adram_ctrl.sv
module adram_ctrl #(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int DW    = 8,
  parameter int TW    = 4,
  parameter int PW    = 12,
  localparam int AW   = ROW_W + COL_W,
  localparam int MAW  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TW-1:0]  cfg_rcd,
  input  logic [TW-1:0]  cfg_cas,
  input  logic [TW-1:0]  cfg_pre,
  input  logic [PW-1:0]  cfg_ref_period,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           req_ready,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic [MAW-1:0] dram_addr,
  output logic           dram_ras_n,
  output logic           dram_cas_n,
  output logic           dram_we_n,
  inout  wire  [DW-1:0]  dram_dq
);
  logic [1:0]    rst_sync_q;
  logic          rst_core;
  logic          ref_pend, ref_ack;
  logic          accept, ld_col, cap, dq_oe;
  logic [DW-1:0] wdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core = rst_sync_q[1];

  adram_refresh_timer #(.PW(PW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_core),
    .period (cfg_ref_period),
    .ack    (ref_ack),
    .pend   (ref_pend)
  );

  adram_seq #(.TW(TW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core),
    .cfg_rcd   (cfg_rcd),
    .cfg_cas   (cfg_cas),
    .cfg_pre   (cfg_pre),
    .req_valid (req_valid),
    .req_write (req_write),
    .ref_pend  (ref_pend),
    .req_ready (req_ready),
    .accept    (accept),
    .ref_ack   (ref_ack),
    .ld_col    (ld_col),
    .cap       (cap),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .dq_oe     (dq_oe)
  );

  adram_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_core),
    .accept    (accept),
    .ld_col    (ld_col),
    .cap       (cap),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (dram_dq),
    .mem_addr  (dram_addr),
    .wdata     (wdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  assign dram_dq = dq_oe ? wdata : {DW{1'bz}};
endmodule

// File: rtl/adram_ctrl_chk.sv
module adram_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic rd_valid,
  input logic dq_oe
);
  // R5
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(we_n));

  // R7
  cbr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |-> we_n);

  // R2
  row_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> $past(!ras_n));

  // R4
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);

  // R3
  joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> cas_n);

  // R6
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R10
  bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && !ras_n));
endmodule

bind adram_ctrl adram_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_core),
  .ras_n    (dram_ras_n),
  .cas_n    (dram_cas_n),
  .we_n     (dram_we_n),
  .rd_valid (rd_valid),
  .dq_oe    (dq_oe)
);

// File: tb/adram_ctrl_tb.sv
`timescale 1ns/1ps
module adram_ctrl_tb;
  localparam int ROW_W = 4, COL_W = 4, DW = 8, TW = 4, PW = 12;
  localparam int AW = ROW_W + COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] cfg_rcd = '0, cfg_cas = '0, cfg_pre = '0;
  logic [PW-1:0] cfg_ref_period = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [3:0] dram_addr;
  logic ras_n, cas_n, we_n;
  wire  [DW-1:0] dq;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .TW(TW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rcd(cfg_rcd), .cfg_cas(cfg_cas), .cfg_pre(cfg_pre),
    .cfg_ref_period(cfg_ref_period), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_dq(dq));

  // memory model and strobe timing monitor, sampled at the falling clock edge
  logic [DW-1:0] mem [0:255];
  logic [3:0] row_l, col_l;
  logic col_ok;
  logic prev_ras, prev_cas, prev_we, prev_rdv;
  int tcyc, t_ras_fall, t_ras_rise, t_cas_fall, t_cas_rise, t_ref;
  int last_ras_hi, last_ras_lo, last_cas_lo, last_rcd, last_crd, last_ref_gap, rdv_gap;
  int ref_cnt;
  logic we_before, we_at_ref, we_glitch;
  logic [3:0] row_seen, col_seen;

  assign dq = (col_ok && we_n && !cas_n && !ras_n) ? mem[{row_l, col_l}] : {DW{1'bz}};

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras <= 1'b1; prev_cas <= 1'b1; prev_we <= 1'b1; prev_rdv <= 1'b0;
      tcyc <= 0; t_ras_fall <= 0; t_ras_rise <= 0; t_cas_fall <= 0; t_cas_rise <= 0; t_ref <= 0;
      col_ok <= 1'b0; ref_cnt <= 0; we_glitch <= 1'b0;
    end else begin
      tcyc <= tcyc + 1;
      if (prev_ras && !ras_n) begin
        last_ras_hi <= tcyc - t_ras_rise;
        t_ras_fall  <= tcyc;
        if (cas_n) begin row_l <= dram_addr; row_seen <= dram_addr; end
        else last_crd <= tcyc - t_cas_fall;
      end
      if (!prev_ras && ras_n) begin
        last_ras_lo <= tcyc - t_ras_fall;
        t_ras_rise  <= tcyc;
      end
      if (prev_cas && !cas_n) begin
        t_cas_fall <= tcyc;
        if (!ras_n) begin
          last_rcd  <= tcyc - t_ras_fall;
          col_l     <= dram_addr;
          col_seen  <= dram_addr;
          col_ok    <= 1'b1;
          we_before <= prev_we;
          if (!we_n) mem[{row_l, dram_addr}] <= dq;
        end else begin
          if (ref_cnt > 0) last_ref_gap <= tcyc - t_ref;
          t_ref     <= tcyc;
          ref_cnt   <= ref_cnt + 1;
          we_at_ref <= we_n;
        end
      end
      if (!prev_cas && cas_n) begin
        last_cas_lo <= tcyc - t_cas_fall;
        t_cas_rise  <= tcyc;
        col_ok      <= 1'b0;
      end
      if (!cas_n && !prev_cas && (we_n != prev_we)) we_glitch <= 1'b1;
      if (rd_valid && !prev_rdv) rdv_gap <= (!prev_cas && cas_n) ? 0 : tcyc - t_cas_rise;
      prev_ras <= ras_n; prev_cas <= cas_n; prev_we <= we_n; prev_rdv <= rd_valid;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    issue(1'b0, a, '0);
    while (!rd_valid) @(negedge clk);
    d = rd_data;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int t0, rc0, exp_min;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: levels under reset
    chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
    chk(!rd_valid, "R1 rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n && req_ready && !rd_valid, "R1 after release",
        {ras_n, cas_n, we_n, req_ready, rd_valid}, 5'b11110);

    // R2 R3 R4 R5 R6 R10 R11: sweep of every small timing including zeros
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        for (int p = 0; p < 3; p++) begin
          logic [AW-1:0] a0, a1;
          logic [DW-1:0] d0, d1;
          cfg_rcd = TW'(r); cfg_cas = TW'(c); cfg_pre = TW'(p);
          a0 = AW'(r * 64 + c * 16 + p * 5 + 1);
          a1 = AW'(a0 + 8'd37 + 8'(p));
          d0 = DW'(a0 ^ 8'h5A);
          d1 = DW'(a1 + 8'h33);
          issue(1'b1, a0, d0);
          issue(1'b1, a1, d1);
          settle();
          chk(last_ras_hi == eff(p) + 1, "R4 back-to-back precharge", last_ras_hi, eff(p) + 1);
          chk(last_rcd == eff(r), "R2 row-to-column delay", last_rcd, eff(r));
          chk(last_cas_lo == eff(c), "R3 column pulse", last_cas_lo, eff(c));
          chk(last_ras_lo == eff(r) + eff(c), "R3 row pulse", last_ras_lo, eff(r) + eff(c));
          chk(row_seen == a1[7:4] && col_seen == a1[3:0], "R2 address split",
              {row_seen, col_seen}, a1);
          chk(we_before == 1'b0 && !we_glitch, "R5 write enable setup", we_before, 0);
          chk(mem[a1] == d1, "R5 write data at column fall", mem[a1], d1);
          rd(a0, d);
          chk(d == d0, "R10 read back first", d, d0);
          rd(a1, d);
          chk(d == d1, "R10 read back second", d, d1);
          settle();
          chk(rdv_gap == 0, "R6 rd_valid placement", rdv_gap, 0);
          chk(we_before == 1'b1 && we_n, "R5 read keeps we high", we_before, 1);
          chk(last_ras_hi >= eff(p) + 1, "R4 minimum precharge", last_ras_hi, eff(p) + 1);
        end
      end
    end

    // R8 R7: idle refresh cadence and strobe order
    cfg_rcd = 4'd2; cfg_cas = 4'd3; cfg_pre = 4'd1;
    cfg_ref_period = 12'd20;
    repeat (90) @(negedge clk);
    #1;
    chk(last_ref_gap == 20, "R8 idle interval", last_ref_gap, 20);
    chk(last_crd == 2, "R7 column-to-row delay", last_crd, 2);
    chk(last_ras_lo == 3, "R7 row pulse in refresh", last_ras_lo, 3);
    chk(last_cas_lo == 5, "R7 column pulse in refresh", last_cas_lo, 5);
    chk(we_at_ref == 1'b1, "R7 no write in refresh", we_at_ref, 1);

    // R8: period zero stops refresh
    cfg_ref_period = 12'd0;
    settle();
    rc0 = ref_cnt;
    repeat (300) @(negedge clk);
    #1;
    chk(ref_cnt == rc0, "R8 disabled refresh", ref_cnt - rc0, 0);

    // R9: refresh under continuous traffic
    cfg_rcd = 4'd1; cfg_cas = 4'd1; cfg_pre = 4'd1;
    cfg_ref_period = 12'd25;
    t0 = tcyc; rc0 = ref_cnt;
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 7 + 3);
      issue(1'b1, a, DW'(i * 3 + 1));
      rd(a, d);
      chk(d == DW'(i * 3 + 1), "R9 data under refresh traffic", d, i * 3 + 1);
    end
    #1;
    exp_min = (tcyc - t0) / 25 - 1;
    chk(ref_cnt - rc0 >= exp_min, "R9 refresh not starved", ref_cnt - rc0, exp_min);
    chk(last_ref_gap >= 21 && last_ref_gap <= 29, "R9 refresh spacing", last_ref_gap, 25);
    chk(!we_glitch, "R5 we stable across run", we_glitch, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule